// File: doc/BRIEF.md
# Shared Bus Arbitration Node

This block is the arbitration logic that sits in each processor of a cluster of up to eight nodes sharing a single external bus. Each node owns one bit of an eight-bit request bus. It chooses that bit from a node identifier captured while reset is held. Every node watches the whole request bus and the two shared priority flags. Every node runs the same ownership rules, so all nodes track the same owner without a central arbiter.

Ownership moves only when the current owner's request line goes low. The next owner is the first requester found in rotating order after the current owner. Preemption is carried by the request lines themselves. When the shared core-priority flag is up, a node with no pending core access withdraws its request. When only the DMA-priority flag is up, a node carrying nothing but normal DMA withdraws. An owner that withdraws in this way loses the bus on the next sample. A bus lock makes the owner immune to these flags. A host back-off aimed at host-space traffic makes the owner drop its line for exactly one cycle and flag a retry. After that cycle the request comes back.

Top module: `busarb_node`

## Requirements
- R1: While reset is held, and until arbitration first resolves, the owner is node 0. `bus_master` is high only in the node whose identifier is 0, and `req_lines_out` is all zero.
- R2: `req_lines_out` is either zero or has exactly bit k set, where k is the value of `node_id` captured during reset. Changes to `node_id` after reset have no effect.
- R3: `cpa_out` equals `core_req` and `dpa_out` equals `dma_hi_req`, each one clock later.
- R4: On each clock edge where the owner's line in `req_lines_in` is low and some line is high, `owner_id` becomes the first set line found in the order owner+1, owner+2, … modulo 8. This change is visible right after that edge. `bus_master` is high exactly when `owner_id` equals the captured identifier.
- R5: On an edge where no request line is set, the owner is unchanged.
- R6: While `cpa_in` is high and no lock is held, a node without `core_req` drives no request line from the next clock on.
- R7: While `dpa_in` is high and no lock is held, a node whose only pending work is normal DMA drives no request line from the next clock on. A pending high-priority DMA or core request keeps the line driven.
- R8: When `backoff_in` and `host_target` are both high while the node owns the bus and drives its line, the line is low for exactly the next cycle and `retry_out` pulses in that cycle. After that cycle the line returns if a request is still pending.
- R9: A back-off with `host_target` low is ignored: the line stays driven and `retry_out` stays low.
- R10: `lock_out` rises one clock after `lock_req` while the node owns the bus and keeps its request. While `lock_out` is high, the priority flags do not withdraw the request, so ownership is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; node_id is captured while it is high |
| node_id | input | 3 | Node identifier, sampled only during reset |
| req_lines_in | input | 8 | Observed request bus, all nodes, own line included |
| cpa_in | input | 1 | Observed shared core-priority flag |
| dpa_in | input | 1 | Observed shared DMA-priority flag |
| core_req | input | 1 | Local core needs the external bus |
| dma_hi_req | input | 1 | Local high-priority DMA needs the bus |
| dma_norm_req | input | 1 | Local normal-priority DMA needs the bus |
| lock_req | input | 1 | Local request to lock the bus while owning it |
| host_target | input | 1 | Outstanding transaction targets host memory space |
| backoff_in | input | 1 | Host back-off request |
| req_lines_out | output | 8 | This node's drive onto the request bus |
| cpa_out | output | 1 | This node's contribution to the core-priority flag |
| dpa_out | output | 1 | This node's contribution to the DMA-priority flag |
| bus_master | output | 1 | This node owns the bus |
| lock_out | output | 1 | Bus-lock indication |
| retry_out | output | 1 | One-cycle pulse: aborted transaction must restart |
| owner_id | output | 3 | Identifier of the current owner |

## Verification
The bench resets the node under every identifier. A decoder that is off by one or bit-reversed would drive the wrong line, and a node other than 0 would claim the bus after reset. A long walk through request patterns covers every owner position, including wrap past node 7 and the empty bus. A rotation that searched from index 0, or that moved ownership while the owner's line was still high, gives a wrong owner there. The directed part checks four cases. A preempted owner must drop its line one cycle later and lose the bus one cycle after that. A lock must hold off the core-priority flag. A back-off must give exactly one idle cycle and a retry pulse. A back-off aimed elsewhere must change nothing, where a design without the target qualifier would abort the transaction anyway.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  // Local traffic class, highest value wins.
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_NORM = 2'd1,
    CLS_HI   = 2'd2,
    CLS_CORE = 2'd3
  } req_class_e;

  function automatic req_class_e classify(input logic core, input logic hi, input logic norm);
    if (core)      return CLS_CORE;
    else if (hi)   return CLS_HI;
    else if (norm) return CLS_NORM;
    else           return CLS_NONE;
  endfunction

endpackage

// File: rtl/busarb_id_decode.sv
module busarb_id_decode #(
  parameter int NODES = 8,
  localparam int IDW = $clog2(NODES)
) (
  input  logic [IDW-1:0]   id,
  output logic [NODES-1:0] onehot
);

  for (genvar g = 0; g < NODES; g++) begin : g_line
    assign onehot[g] = (id == IDW'(g));
  end

endmodule

// File: rtl/busarb_rr_pick.sv
module busarb_rr_pick #(
  parameter int NODES = 8,
  localparam int IDW = $clog2(NODES)
) (
  input  logic [NODES-1:0] req,
  input  logic [IDW-1:0]   last,
  output logic             found,
  output logic [IDW-1:0]   pick
);

  // Search starts one past the last owner and wraps.
  always_comb begin
    int unsigned idx;
    found = 1'b0;
    pick  = last;
    idx   = 0;
    for (int i = 1; i <= NODES; i++) begin
      idx = (int'(last) + i) % NODES;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end

  always_comb begin
    if (found) begin
      a_pick_valid_r4 : assert (req[pick]);
    end
  end

endmodule

// File: rtl/busarb_owner_track.sv
module busarb_owner_track #(
  parameter int NODES = 8,
  localparam int IDW = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDW-1:0]   id_raw,
  input  logic [IDW-1:0]   id_q,
  input  logic [NODES-1:0] req_lines,
  output logic [IDW-1:0]   owner_q,
  output logic             master_q
);

  logic           found;
  logic [IDW-1:0] pick;
  logic [IDW-1:0] owner_nxt;

  busarb_rr_pick #(.NODES(NODES)) u_pick (
    .req   (req_lines),
    .last  (owner_q),
    .found (found),
    .pick  (pick)
  );

  always_comb begin
    owner_nxt = owner_q;
    if (!req_lines[owner_q] && found) owner_nxt = pick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= '0;
      master_q <= (id_raw == '0);
    end else begin
      owner_q  <= owner_nxt;
      master_q <= (owner_nxt == id_q);
    end
  end

  p_owner_hold_r4 : assert property (@(posedge clk) disable iff (rst)
    req_lines[owner_q] |=> $stable(owner_q));

  p_handoff_r4 : assert property (@(posedge clk) disable iff (rst)
    (!req_lines[owner_q] && (|req_lines)) |=> (owner_q != $past(owner_q)));

  p_park_r5 : assert property (@(posedge clk) disable iff (rst)
    (req_lines == '0) |=> $stable(owner_q));

endmodule

// File: rtl/busarb_req_ctrl.sv
module busarb_req_ctrl
  import busarb_pkg::*;
#(
  parameter int NODES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] my_line,
  input  logic             master_q,
  input  logic             core_req,
  input  logic             dma_hi_req,
  input  logic             dma_norm_req,
  input  logic             lock_req,
  input  logic             host_target,
  input  logic             backoff_in,
  input  logic             cpa_in,
  input  logic             dpa_in,
  output logic [NODES-1:0] br_q,
  output logic             cpa_q,
  output logic             dpa_q,
  output logic             lock_q,
  output logic             retry_q
);

  req_class_e cls;
  logic       bo_acc;
  logic       supp;
  logic       drive;

  always_comb begin
    cls    = classify(core_req, dma_hi_req, dma_norm_req);
    bo_acc = backoff_in && host_target && master_q && (|br_q);
    supp   = !lock_q && ((cpa_in && cls != CLS_CORE) ||
                         (dpa_in && cls == CLS_NORM));
    drive  = (cls != CLS_NONE) && !supp && !bo_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br_q    <= '0;
      cpa_q   <= 1'b0;
      dpa_q   <= 1'b0;
      lock_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      br_q    <= drive ? my_line : '0;
      cpa_q   <= core_req;
      dpa_q   <= dma_hi_req;
      lock_q  <= lock_req && master_q && (|br_q) && drive;
      retry_q <= bo_acc;
    end
  end

  p_br_onehot_r2 : assert property (@(posedge clk) disable iff (rst)
    $onehot0(br_q));

  p_backoff_drop_r8 : assert property (@(posedge clk) disable iff (rst)
    (backoff_in && host_target && master_q && (|br_q)) |=> (br_q == '0 && retry_q));

  p_backoff_ignored_r9 : assert property (@(posedge clk) disable iff (rst)
    (!host_target) |=> !retry_q);

endmodule

// File: rtl/busarb_node.sv
module busarb_node #(
  parameter int NODES = 8,
  localparam int IDW = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDW-1:0]   node_id,
  input  logic [NODES-1:0] req_lines_in,
  input  logic             cpa_in,
  input  logic             dpa_in,
  input  logic             core_req,
  input  logic             dma_hi_req,
  input  logic             dma_norm_req,
  input  logic             lock_req,
  input  logic             host_target,
  input  logic             backoff_in,
  output logic [NODES-1:0] req_lines_out,
  output logic             cpa_out,
  output logic             dpa_out,
  output logic             bus_master,
  output logic             lock_out,
  output logic             retry_out,
  output logic [IDW-1:0]   owner_id
);

  logic [IDW-1:0]   id_q;
  logic [NODES-1:0] my_line;
  logic             master_q;
  logic             lock_q;

  // Identifier is only captured while reset is held.
  always_ff @(posedge clk) begin
    if (rst) id_q <= node_id;
  end

  busarb_id_decode #(.NODES(NODES)) u_dec (
    .id     (id_q),
    .onehot (my_line)
  );

  busarb_owner_track #(.NODES(NODES)) u_own (
    .clk       (clk),
    .rst       (rst),
    .id_raw    (node_id),
    .id_q      (id_q),
    .req_lines (req_lines_in),
    .owner_q   (owner_id),
    .master_q  (master_q)
  );

  busarb_req_ctrl #(.NODES(NODES)) u_req (
    .clk          (clk),
    .rst          (rst),
    .my_line      (my_line),
    .master_q     (master_q),
    .core_req     (core_req),
    .dma_hi_req   (dma_hi_req),
    .dma_norm_req (dma_norm_req),
    .lock_req     (lock_req),
    .host_target  (host_target),
    .backoff_in   (backoff_in),
    .cpa_in       (cpa_in),
    .dpa_in       (dpa_in),
    .br_q         (req_lines_out),
    .cpa_q        (cpa_out),
    .dpa_q        (dpa_out),
    .lock_q       (lock_q),
    .retry_q      (retry_out)
  );

  assign bus_master = master_q;
  assign lock_out   = lock_q;

  p_id_stable_r2 : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(id_q));

  p_lock_master_r10 : assert property (@(posedge clk) disable iff (rst)
    lock_q |-> master_q);

  p_reset_idle_r1 : assert property (@(posedge clk)
    $past(rst) |-> (req_lines_out == '0 && !lock_q && !retry_out));

endmodule

// File: tb/tb_busarb_node.sv
`timescale 1ns/1ps
module tb_busarb_node;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] node_id = '0;
  logic [7:0] others = '0;
  logic [7:0] req_lines_in;
  logic       cpa_in = 0, dpa_in = 0;
  logic       core_req = 0, dma_hi_req = 0, dma_norm_req = 0;
  logic       lock_req = 0, host_target = 0, backoff_in = 0;
  logic [7:0] req_lines_out;
  logic       cpa_out, dpa_out, bus_master, lock_out, retry_out;
  logic [2:0] owner_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign req_lines_in = req_lines_out | others;

  busarb_node dut (
    .clk(clk), .rst(rst), .node_id(node_id), .req_lines_in(req_lines_in),
    .cpa_in(cpa_in), .dpa_in(dpa_in), .core_req(core_req),
    .dma_hi_req(dma_hi_req), .dma_norm_req(dma_norm_req), .lock_req(lock_req),
    .host_target(host_target), .backoff_in(backoff_in),
    .req_lines_out(req_lines_out), .cpa_out(cpa_out), .dpa_out(dpa_out),
    .bus_master(bus_master), .lock_out(lock_out), .retry_out(retry_out),
    .owner_id(owner_id)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int rr_next(input int own, input logic [7:0] lines);
    for (int i = 1; i <= 8; i++) begin
      if (lines[(own + i) % 8]) return (own + i) % 8;
    end
    return own;
  endfunction

  initial begin
    int own;
    logic [7:0] lines;
    // R1 / R2 / R3: reset under every identifier
    for (int id = 0; id < 8; id++) begin
      @(negedge clk);
      rst = 1; node_id = 3'(id); core_req = 0; others = '0;
      cyc(2);
      chk(bus_master == (id == 0), "R1 master at reset", bus_master, id == 0);
      chk(owner_id == 0, "R1 owner at reset", owner_id, 0);
      chk(req_lines_out == 0, "R1 lines at reset", req_lines_out, 0);
      rst = 0;
      cyc(1);
      chk(bus_master == (id == 0), "R1 master after reset", bus_master, id == 0);
      core_req = 1;
      cyc(1);
      chk(req_lines_out == 8'(1 << id), "R2 line select", req_lines_out, 1 << id);
      chk(cpa_out == 1, "R3 cpa follows", cpa_out, 1);
      core_req = 0;
      cyc(1);
      chk(cpa_out == 0, "R3 cpa clears", cpa_out, 0);
    end

    // Main configuration: identifier 2
    rst = 1; node_id = 3'd2;
    cyc(2);
    rst = 0; node_id = 3'd5;   // R2: ignored after reset
    cyc(1);

    // R4 / R5: rotation sweep, this node idle
    own = 0;
    for (int m = 0; m < 128; m++) begin
      lines = {m[6:2], 1'b0, m[1:0]};
      lines[own] = 1'b0;
      others = lines;
      cyc(1);
      own = (lines == 0) ? own : rr_next(own, lines);
      chk(owner_id == 3'(own), (lines == 0) ? "R5 park" : "R4 rotate", owner_id, own);
      chk(bus_master == 0, "R4 not master", bus_master, 0);
    end
    others = '0;
    cyc(1);

    // R2 / R4: own request, identifier change ignored
    core_req = 1;
    cyc(1);
    chk(req_lines_out == 8'h04, "R2 id held after reset", req_lines_out, 4);
    cyc(1);
    chk(owner_id == 2, "R4 gain owner", owner_id, 2);
    chk(bus_master == 1, "R4 gain master", bus_master, 1);

    // R6: core-priority preemption of normal DMA
    core_req = 0; dma_norm_req = 1;
    cyc(1);
    others = 8'h20; cpa_in = 1;
    cyc(1);
    chk(req_lines_out == 0, "R6 withdraw", req_lines_out, 0);
    cyc(1);
    chk(owner_id == 5, "R6 lose owner", owner_id, 5);
    chk(bus_master == 0, "R6 lose master", bus_master, 0);
    cpa_in = 0; others = '0;
    cyc(2);
    chk(bus_master == 1, "R4 regain", bus_master, 1);

    // R7: DMA-priority flag
    dpa_in = 1;
    cyc(1);
    chk(req_lines_out == 0, "R7 normal withdraws", req_lines_out, 0);
    dma_hi_req = 1;
    cyc(1);
    chk(req_lines_out == 8'h04, "R7 high keeps line", req_lines_out, 4);
    chk(dpa_out == 1, "R3 dpa follows", dpa_out, 1);
    chk(bus_master == 1, "R7 still master", bus_master, 1);
    dpa_in = 0; dma_hi_req = 0;
    cyc(1);

    // R10: lock holds off the core-priority flag
    lock_req = 1;
    cyc(1);
    chk(lock_out == 1, "R10 lock rises", lock_out, 1);
    cpa_in = 1; others = 8'h40;
    cyc(2);
    chk(req_lines_out == 8'h04, "R10 line kept", req_lines_out, 4);
    chk(owner_id == 2, "R10 owner kept", owner_id, 2);
    lock_req = 0;
    cyc(3);
    chk(lock_out == 0, "R10 lock falls", lock_out, 0);
    chk(owner_id == 6, "R10 released", owner_id, 6);
    cpa_in = 0; others = '0;
    cyc(2);
    chk(bus_master == 1, "R4 regain after lock", bus_master, 1);

    // R9: back-off aimed elsewhere
    host_target = 0; backoff_in = 1;
    cyc(1);
    backoff_in = 0;
    chk(req_lines_out == 8'h04, "R9 line kept", req_lines_out, 4);
    chk(retry_out == 0, "R9 no retry", retry_out, 0);
    chk(bus_master == 1, "R9 still master", bus_master, 1);

    // R8: back-off to host space
    host_target = 1; backoff_in = 1; others = 8'h01;
    cyc(1);
    backoff_in = 0;
    chk(req_lines_out == 0, "R8 line dropped", req_lines_out, 0);
    chk(retry_out == 1, "R8 retry pulse", retry_out, 1);
    cyc(1);
    chk(req_lines_out == 8'h04, "R8 line returns", req_lines_out, 4);
    chk(retry_out == 0, "R8 retry one cycle", retry_out, 0);
    chk(owner_id == 0, "R8 bus handed over", owner_id, 0);
    chk(bus_master == 0, "R8 not master", bus_master, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule